// File: doc/BRIEF.md
# Configurable Two-Table Logic Slice

This block models one programmable logic slice. Two 4-input look-up tables hold 16-bit truth tables. A multiplexer steered by a fifth input joins the two table results, so the slice can form any function of five inputs. Each table also drives its own storage element. That element can act as an edge-triggered flip-flop or as a level-sensitive latch. It has a clock enable and set and clear controls. The set and clear act either synchronously or asynchronously, and each control can be used true or inverted. A per-cell output multiplexer picks either the raw table result or the stored value.

All configuration lives in one 44-bit word loaded serially. While `cfg_en` is high, one bit enters per rising clock edge. Outputs are not defined while a load is in progress. Once `cfg_en` returns low, the word stays fixed and the slice acts as the configured logic.

Top module: `lut_slice`

## Requirements
- R1: While cfg_en is high, each rising clock edge shifts cfg_din into bit 43 and moves every configuration bit one place toward bit 0, so after 44 edges the first bit sent sits at bit 0. Layout: bits 15:0 are table A, bits 31:16 are table B, bits 37:32 are mode A and bits 43:38 are mode B. Within a mode field, bit 0 selects stored output, bit 1 selects latch, bit 2 selects asynchronous set/clear, bit 3 inverts the enable, bit 4 inverts set and bit 5 inverts clear. While cfg_en is low, the configuration does not change.
- R2: A synchronous active-high rst clears the whole configuration and both storage elements. After reset, every output is 0.
- R3: The combinational result of a table is table bit {in3,in2,in1,in0}, with input bit 0 as the least significant bit of the index.
- R4: f5_out equals the combinational result of table A when sel5 is 0 and of table B when sel5 is 1.
- R5: With mode bit 0 clear, a cell output follows its table result with no clock. With mode bit 0 set, the output shows the stored value.
- R6: In flip-flop mode, the element captures the table result on a rising edge while the enable is active, and holds its value while the enable is inactive.
- R7: In latch mode, the element is transparent while clk is low and the enable is active. It holds while clk is high or while the enable is inactive.
- R8: With synchronous set/clear, an active set or clear changes a flip-flop only at the next rising edge, and it overrides the data.
- R9: With asynchronous set/clear, an active set or clear forces the output at once. A value held across a rising edge stays stored after the control is released.
- R10: When set and clear are both active, clear wins.
- R11: When the matching inversion bit is set, the enable, set and clear inputs are active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the gate of a latch-mode element (transparent when low) |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data |
| a_in | input | 4 | Index inputs of table A |
| b_in | input | 4 | Index inputs of table B |
| sel5 | input | 1 | Fifth input; picks table B when high |
| ce_in | input | 1 | Storage clock enable (polarity per cell) |
| set_in | input | 1 | Storage set (polarity per cell) |
| clr_in | input | 1 | Storage clear (polarity per cell) |
| a_out | output | 1 | Cell A output (combinational or stored) |
| b_out | output | 1 | Cell B output (combinational or stored) |
| f5_out | output | 1 | Combined five-input function result |

## Verification
A wrong configuration bit shows as soon as a table index that reads it is applied. It is therefore visible on a_out, b_out or f5_out in the same cycle for combinational cells, so the bench sweeps every index of both tables and both fifth-input values. A wrong stored value shows only when the output multiplexer selects storage. For a flip-flop it appears one rising edge after the capture or the synchronous control. For a latch or an asynchronous control it appears within the same clock phase. The bench therefore samples both inside the high phase and inside the low phase.

// File: rtl/slice_pkg.sv
package slice_pkg;
    localparam int LUT_K  = 4;
    localparam int TBL_W  = 1 << LUT_K;
    localparam int MODE_W = 6;
    localparam int N_CELL = 2;
    localparam int CFG_W  = N_CELL * (TBL_W + MODE_W);

    // Per-cell mode field, bit 0 first from the bottom.
    typedef struct packed {
        logic rst_inv;     // bit 5
        logic set_inv;     // bit 4
        logic ce_inv;      // bit 3
        logic sr_async;    // bit 2
        logic latch_mode;  // bit 1
        logic use_store;   // bit 0
    } cell_mode_t;

    typedef struct packed {
        logic ce;
        logic set;
        logic clr;
    } ctl_t;

    function automatic ctl_t ctl_resolve(cell_mode_t m, logic ce, logic set, logic clr);
        ctl_t r;
        r.ce  = ce  ^ m.ce_inv;
        r.set = set ^ m.set_inv;
        r.clr = clr ^ m.rst_inv;
        return r;
    endfunction
endpackage

// File: rtl/slice_cfg_chain.sv
module slice_cfg_chain #(
    parameter int W = 44
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (shift_en)
            cfg_q <= {din, cfg_q[W-1:1]};
    end
endmodule

// File: rtl/lut_eval.sv
module lut_eval #(
    parameter int K = 4,
    localparam int N = 1 << K
) (
    input  logic [N-1:0] table_bits,
    input  logic [K-1:0] idx,
    output logic         y
);
    assign y = table_bits[idx];
endmodule

// File: rtl/slice_store.sv
module slice_store
    import slice_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cell_mode_t mode,
    input  logic       d,
    input  logic       ce_in,
    input  logic       set_in,
    input  logic       clr_in,
    output logic       q_out
);
    ctl_t act;
    logic ff_q;
    logic lat_q;
    logic held;
    logic forced_clr;
    logic forced_set;

    assign act        = ctl_resolve(mode, ce_in, set_in, clr_in);
    assign forced_clr = mode.sr_async && act.clr;
    assign forced_set = mode.sr_async && act.set;

    // Edge-triggered element: clear beats set beats data.
    always_ff @(posedge clk) begin
        if (rst)
            ff_q <= 1'b0;
        else if (act.clr)
            ff_q <= 1'b0;
        else if (act.set)
            ff_q <= 1'b1;
        else if (act.ce)
            ff_q <= d;
    end

    // Level-sensitive element, open while the clock is low.
    always_latch begin
        if (rst)
            lat_q = 1'b0;
        else if (forced_clr)
            lat_q = 1'b0;
        else if (forced_set)
            lat_q = 1'b1;
        else if (!clk) begin
            if (act.clr)
                lat_q = 1'b0;
            else if (act.set)
                lat_q = 1'b1;
            else if (act.ce)
                lat_q = d;
        end
    end

    always_comb begin
        if (forced_clr)
            held = 1'b0;
        else if (forced_set)
            held = 1'b1;
        else
            held = mode.latch_mode ? lat_q : ff_q;
    end

    assign q_out = mode.use_store ? held : d;
endmodule

// File: rtl/lut_slice.sv
module lut_slice
    import slice_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_din,
    input  logic [LUT_K-1:0] a_in,
    input  logic [LUT_K-1:0] b_in,
    input  logic             sel5,
    input  logic             ce_in,
    input  logic             set_in,
    input  logic             clr_in,
    output logic             a_out,
    output logic             b_out,
    output logic             f5_out
);
    localparam int MODE_BASE = N_CELL * TBL_W;

    logic [CFG_W-1:0]  cfg_word;
    logic [LUT_K-1:0]  cell_idx [N_CELL];
    logic [N_CELL-1:0] lut_y;
    logic [N_CELL-1:0] cell_q;

    assign cell_idx[0] = a_in;
    assign cell_idx[1] = b_in;

    slice_cfg_chain #(.W(CFG_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_en),
        .din      (cfg_din),
        .cfg_q    (cfg_word)
    );

    for (genvar c = 0; c < N_CELL; c++) begin : g_cell
        cell_mode_t mode_c;
        assign mode_c = cell_mode_t'(cfg_word[MODE_BASE + c*MODE_W +: MODE_W]);

        lut_eval #(.K(LUT_K)) u_lut (
            .table_bits (cfg_word[c*TBL_W +: TBL_W]),
            .idx        (cell_idx[c]),
            .y          (lut_y[c])
        );

        slice_store u_store (
            .clk    (clk),
            .rst    (rst),
            .mode   (mode_c),
            .d      (lut_y[c]),
            .ce_in  (ce_in),
            .set_in (set_in),
            .clr_in (clr_in),
            .q_out  (cell_q[c])
        );
    end

    assign a_out  = cell_q[0];
    assign b_out  = cell_q[1];
    assign f5_out = sel5 ? lut_y[1] : lut_y[0];
endmodule

// File: rtl/lut_slice_chk.sv
module lut_slice_chk
    import slice_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_en,
    input logic [CFG_W-1:0] cfg_q,
    input logic [LUT_K-1:0] a_in,
    input logic [LUT_K-1:0] b_in,
    input logic             sel5,
    input logic             ce_in,
    input logic             set_in,
    input logic             clr_in,
    input logic             a_out,
    input logic             b_out,
    input logic             f5_out
);
    cell_mode_t ma;
    cell_mode_t mb;
    assign ma = cell_mode_t'(cfg_q[2*TBL_W +: MODE_W]);
    assign mb = cell_mode_t'(cfg_q[2*TBL_W + MODE_W +: MODE_W]);

    a_r1_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(cfg_q));

    a_r3_lut_a: assert property (@(posedge clk) disable iff (rst)
        !ma.use_store |-> a_out == cfg_q[a_in]);

    a_r3_lut_b: assert property (@(posedge clk) disable iff (rst)
        !mb.use_store |-> b_out == cfg_q[TBL_W + b_in]);

    a_r4_f5_pick: assert property (@(posedge clk) disable iff (rst)
        f5_out == (sel5 ? cfg_q[TBL_W + b_in] : cfg_q[a_in]));

    a_r6_hold_a: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && ma.use_store && !ma.latch_mode && !ma.sr_async &&
         !(ce_in ^ ma.ce_inv) && !(set_in ^ ma.set_inv) && !(clr_in ^ ma.rst_inv))
        |=> $stable(a_out));

    a_r6_hold_b: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && mb.use_store && !mb.latch_mode && !mb.sr_async &&
         !(ce_in ^ mb.ce_inv) && !(set_in ^ mb.set_inv) && !(clr_in ^ mb.rst_inv))
        |=> $stable(b_out));

    a_r8_sync_clr: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && ma.use_store && !ma.latch_mode && !ma.sr_async && (clr_in ^ ma.rst_inv))
        |=> !a_out);

    a_r9_async_clr: assert property (@(posedge clk) disable iff (rst)
        (ma.use_store && ma.sr_async && (clr_in ^ ma.rst_inv)) |-> !a_out);
endmodule

bind lut_slice lut_slice_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .cfg_en (cfg_en),
    .cfg_q  (cfg_word),
    .a_in   (a_in),
    .b_in   (b_in),
    .sel5   (sel5),
    .ce_in  (ce_in),
    .set_in (set_in),
    .clr_in (clr_in),
    .a_out  (a_out),
    .b_out  (b_out),
    .f5_out (f5_out)
);

// File: tb/lut_slice_test.sv
`timescale 1ns/1ps
module lut_slice_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_en = 1'b0, cfg_din = 1'b0;
    logic [3:0] a_in = '0, b_in = '0;
    logic sel5 = 1'b0, ce_in = 1'b0, set_in = 1'b0, clr_in = 1'b0;
    logic a_out, b_out, f5_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    localparam logic [15:0] TA = 16'hC35A;
    localparam logic [15:0] TB = 16'h6996;
    localparam logic [15:0] TS_A = 16'hAAAA;  // result = in0
    localparam logic [15:0] TS_B = 16'h5555;  // result = !in0

    always #2.5 clk = ~clk;

    lut_slice uut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .a_in(a_in), .b_in(b_in), .sel5(sel5), .ce_in(ce_in),
        .set_in(set_in), .clr_in(clr_in),
        .a_out(a_out), .b_out(b_out), .f5_out(f5_out)
    );

    function automatic logic [5:0] mk(bit us, bit lt, bit as, bit ci, bit si, bit ri);
        return {ri, si, ci, as, lt, us};
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edge1();
        @(posedge clk);
        #1;
    endtask

    task automatic load_cfg(logic [43:0] v);
        cfg_en = 1'b1;
        for (int i = 0; i < 44; i++) begin
            cfg_din = v[i];
            edge1();
        end
        cfg_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R2 reset a_out", a_out, 1'b0);
        chk("R2 reset f5_out", f5_out, 1'b0);
        load_cfg({6'd0, 6'd0, 16'hFFFF, 16'hFFFF});
        a_in = 4'h3; b_in = 4'h3;
        #0.5;
        chk("R2 before reset b_out", b_out, 1'b1);
        rst = 1'b1;
        edge1();
        rst = 1'b0;
        chk("R2 cleared a_out", a_out, 1'b0);
        chk("R2 cleared b_out", b_out, 1'b0);
        chk("R2 cleared f5_out", f5_out, 1'b0);
    endtask

    task automatic t_lut();
        load_cfg({6'd0, 6'd0, TB, TA});
        for (int i = 0; i < 16; i++) begin
            a_in = 4'(i); b_in = 4'(15 - i);
            #0.2;
            chk("R3 table A", a_out, TA[i]);
            chk("R3 table B", b_out, TB[15 - i]);
        end
        cfg_en = 1'b0;
        for (int i = 0; i < 8; i++) begin
            cfg_din = i[0];
            edge1();
        end
        a_in = 4'h0; b_in = 4'h5;
        #0.2;
        chk("R1 hold first bit", a_out, TA[0]);
        chk("R1 hold table B", b_out, TB[5]);
    endtask

    task automatic t_f5();
        for (int s = 0; s < 2; s++) begin
            for (int x = 0; x < 16; x++) begin
                sel5 = s[0]; a_in = 4'(x); b_in = ~4'(x);
                #0.2;
                chk("R4 f5 mux", f5_out, s[0] ? TB[15 - x] : TA[x]);
            end
        end
        sel5 = 1'b0;
    endtask

    task automatic t_flop();
        load_cfg({mk(0,0,0,0,0,0), mk(1,0,0,0,0,0), TS_B, TS_A});
        ce_in = 1'b1; a_in = 4'h1; b_in = 4'h1;
        edge1();
        chk("R6 capture 1", a_out, 1'b1);
        chk("R5 comb b_out", b_out, 1'b0);
        a_in = 4'h0;
        #0.5;
        chk("R5 stored not comb", a_out, 1'b1);
        edge1();
        chk("R6 capture 0", a_out, 1'b0);
        ce_in = 1'b0; a_in = 4'h1;
        edge1();
        edge1();
        chk("R6 enable off holds", a_out, 1'b0);
    endtask

    task automatic t_latch();
        load_cfg({mk(0,0,0,0,0,0), mk(1,1,0,0,0,0), TS_B, TS_A});
        ce_in = 1'b1; a_in = 4'h1;
        #2;
        chk("R7 transparent low", a_out, 1'b1);
        a_in = 4'h0;
        #0.5;
        chk("R7 follows low", a_out, 1'b0);
        edge1();
        a_in = 4'h1;
        #0.5;
        chk("R7 holds high", a_out, 1'b0);
        #1.5;
        chk("R7 opens again", a_out, 1'b1);
        ce_in = 1'b0; a_in = 4'h0;
        #0.5;
        chk("R7 enable off holds", a_out, 1'b1);
        ce_in = 1'b1;
    endtask

    task automatic t_sync();
        load_cfg({mk(0,0,0,0,0,0), mk(1,0,0,0,0,0), TS_B, TS_A});
        ce_in = 1'b1; a_in = 4'h1;
        edge1();
        chk("R8 preload 1", a_out, 1'b1);
        clr_in = 1'b1;
        #0.5;
        chk("R8 clear waits for edge", a_out, 1'b1);
        edge1();
        chk("R8 clear at edge", a_out, 1'b0);
        clr_in = 1'b0; set_in = 1'b1; a_in = 4'h0;
        edge1();
        chk("R8 set beats data", a_out, 1'b1);
        clr_in = 1'b1;
        edge1();
        chk("R10 clear beats set sync", a_out, 1'b0);
        clr_in = 1'b0; set_in = 1'b0;
    endtask

    task automatic t_async();
        load_cfg({mk(0,0,0,0,0,0), mk(1,0,1,0,0,0), TS_B, TS_A});
        ce_in = 1'b1; a_in = 4'h0;
        edge1();
        chk("R9 preload 0", a_out, 1'b0);
        ce_in = 1'b0;
        set_in = 1'b1;
        #0.5;
        chk("R9 set immediate", a_out, 1'b1);
        edge1();
        set_in = 1'b0;
        #0.5;
        chk("R9 set retained", a_out, 1'b1);
        clr_in = 1'b1;
        #0.2;
        chk("R9 clear immediate", a_out, 1'b0);
        set_in = 1'b1;
        #0.2;
        chk("R10 clear beats set async", a_out, 1'b0);
        edge1();
        set_in = 1'b0; clr_in = 1'b0;
        #0.5;
        chk("R9 clear retained", a_out, 1'b0);
    endtask

    task automatic t_polarity();
        ce_in = 1'b0; set_in = 1'b1; clr_in = 1'b1;
        load_cfg({mk(0,0,0,0,0,0), mk(1,0,0,1,1,1), TS_B, TS_A});
        a_in = 4'h1;
        edge1();
        chk("R11 low enable captures", a_out, 1'b1);
        ce_in = 1'b1; a_in = 4'h0;
        edge1();
        chk("R11 high enable holds", a_out, 1'b1);
        clr_in = 1'b0;
        edge1();
        chk("R11 low clear", a_out, 1'b0);
        clr_in = 1'b1; set_in = 1'b0;
        edge1();
        chk("R11 low set", a_out, 1'b1);
        ce_in = 1'b0; set_in = 1'b0; clr_in = 1'b0;
    endtask

    initial begin
        edge1();
        edge1();
        edge1();
        rst = 1'b0;
        t_reset();
        t_lut();
        t_f5();
        t_flop();
        t_latch();
        t_sync();
        t_async();
        t_polarity();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule